// File: doc/BRIEF.md
# IPv4 Header Field Extractor

This block sits on the receive path of one network port. It comes after the stage that checks frame length and CRC. Frames reach it as a byte-lane stream with start-of-frame and end-of-frame markers. As the bytes go by it reads the Ethernet type, the IPv4 header and the first bytes of the transport header. From these it builds a record with the source and destination addresses, the transport ports, the protocol number and the TCP flags byte.

The block also forwards the frame after one register stage. On the beat that holds the first payload byte it raises a flag, and it gives the lane of that byte as an index. A downstream content matcher can then scan the payload alone. IP options and TCP options are skipped by length and are not decoded. A system with several ports uses one instance per port.

The record is presented with a one-cycle valid pulse. The pulse comes in the first cycle that the beat which finishes the header is shown on the output. That beat is the payload-start beat, or the end-of-frame beat when a frame has no payload start. Both streams use valid/ready handshakes. A beat moves only when valid and ready are high on the same rising clock edge. `in_ready` is high whenever the output register is empty or the output side is taking its beat. While `out_valid` is high and `out_ready` is low, every output stays unchanged. There is no ready for the record, so the record cannot be stalled.

Top module: `hfx_extract`

## Requirements
- R1: While reset is high and after it is released with no input, `out_valid` and `rec_valid` are 0 and `in_ready` is 1.
- R2: For an IPv4 frame, the record holds: the source address from frame bytes 26..29, the destination address from bytes 30..33, each with the first byte most significant; the protocol number from byte 23; and the ports from transport bytes 0..1 and 2..3. The frame is IPv4 when bytes 12..13 hold 0x0800 and the upper nibble of byte 14 is 4. The transport header starts at byte 14 + 4*IHL, where IHL is the lower nibble of byte 14.
- R3: For TCP (protocol 6), the payload starts at 14 + 4*IHL + 4*DOFF, where DOFF is the upper nibble of transport byte 12. The flags record field is transport byte 13. Option bytes are passed through unread.
- R4: For UDP (protocol 17), the payload starts 8 bytes after the start of the transport header, and the flags field is 0.
- R5: For any other protocol, the ports and flags are 0, and the payload starts right after the IP header.
- R6: A frame that is not IPv4 gives a record with `rec_not_ipv4` = 1 and every other field 0. It never raises `out_pstart`, and its record comes with the end-of-frame beat.
- R7: Each frame gives exactly one record pulse, one cycle long. It coincides with the first cycle that the payload-start beat is on the output. If the frame has no payload start, it coincides with the end-of-frame beat.
- R8: An IHL or DOFF value below 5 is treated as 5.
- R9: Output beats carry the input bytes unchanged, one cycle after they are accepted. A stalled output beat holds all its fields.
- R10: If a frame ends at or before its payload offset, no payload flag is raised. The record still comes with the end-of-frame beat, and any field whose bytes never arrived reads 0.
- R11: Each beat carries BYTES bytes (1, 2 or 4), with lane 0 first on the wire. `keep` marks the valid lanes on the end-of-frame beat only. The payload flag can fall on any lane, including the last valid lane of a partial final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 8*BYTES | Input bytes, lane 0 in bits 7:0 |
| in_keep | input | BYTES | Valid lanes on the end-of-frame beat |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | 8*BYTES | Forwarded bytes |
| out_keep | output | BYTES | Forwarded lane mask |
| out_sop | output | 1 | Forwarded start marker |
| out_eop | output | 1 | Forwarded end marker |
| out_pstart | output | 1 | This beat holds the first payload byte |
| out_plane | output | max(1,clog2(BYTES)) | Lane of the first payload byte |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_not_ipv4 | output | 1 | Frame was not IPv4 |
| rec_proto | output | 8 | IP protocol number |
| rec_src_ip | output | 32 | IPv4 source address |
| rec_dst_ip | output | 32 | IPv4 destination address |
| rec_src_port | output | 16 | Transport source port |
| rec_dst_port | output | 16 | Transport destination port |
| rec_tcp_flags | output | 8 | TCP flags byte |

## Verification
Some rules are checked on every cycle. A stalled output beat must hold. A record pulse must sit on a beat that is either a payload-start beat or an end-of-frame beat. A frame that is not IPv4 must never raise the payload flag. A protocol other than TCP or UDP must leave the ports and flags at zero. A flagged lane on a partial last beat must be one of the valid lanes. Other behaviour can only be shown by the scenarios, each against values worked out from the header bytes the bench writes. Those are the byte offset where the payload starts for each protocol and header length, the clamping of short length fields, the field values, truncated frames, and byte-exact forwarding under back-pressure.

// File: rtl/hfx_pkg.sv
`timescale 1ns/1ps
package hfx_pkg;
  localparam int OFF_W = 16;

  localparam logic [OFF_W-1:0] POS_ET_HI    = OFF_W'(12);
  localparam logic [OFF_W-1:0] POS_ET_LO    = OFF_W'(13);
  localparam logic [OFF_W-1:0] POS_IP_START = OFF_W'(14);
  localparam logic [OFF_W-1:0] POS_PROTO    = OFF_W'(23);
  localparam logic [OFF_W-1:0] POS_SIP      = OFF_W'(26);
  localparam logic [OFF_W-1:0] POS_DIP      = OFF_W'(30);

  localparam logic [OFF_W-1:0] L4_SPORT = OFF_W'(0);
  localparam logic [OFF_W-1:0] L4_DPORT = OFF_W'(2);
  localparam logic [OFF_W-1:0] L4_DOFF  = OFF_W'(12);
  localparam logic [OFF_W-1:0] L4_FLAGS = OFF_W'(13);
  localparam int               UDP_HDR  = 8;

  localparam logic [15:0] ET_IPV4   = 16'h0800;
  localparam logic [3:0]  VER_IPV4  = 4'd4;
  localparam logic [7:0]  PR_TCP    = 8'd6;
  localparam logic [7:0]  PR_UDP    = 8'd17;
  localparam logic [3:0]  MIN_WORDS = 4'd5;

  // Header bytes collected so far for the frame in flight
  typedef struct packed {
    logic [15:0] etype;
    logic [3:0]  ver;
    logic [3:0]  ihl;
    logic [7:0]  proto;
    logic [31:0] sip;
    logic [31:0] dip;
    logic [15:0] sport;
    logic [15:0] dport;
    logic [3:0]  doff;
    logic [7:0]  flags;
  } hdr_t;

  function automatic logic [OFF_W-1:0] words_to_bytes(input logic [3:0] w);
    logic [3:0] c;
    c = (w < MIN_WORDS) ? MIN_WORDS : w;
    return OFF_W'({c, 2'b00});
  endfunction

  function automatic logic is_ipv4(input logic [15:0] et, input logic [3:0] ver);
    return (et == ET_IPV4) && (ver == VER_IPV4);
  endfunction

  function automatic logic [OFF_W-1:0] l4_off(input logic [3:0] ihl);
    return POS_IP_START + words_to_bytes(ihl);
  endfunction

  function automatic logic [OFF_W-1:0] pay_off(input logic [3:0] ihl,
                                               input logic [7:0] proto,
                                               input logic [3:0] doff);
    logic [OFF_W-1:0] t;
    t = l4_off(ihl);
    if (proto == PR_TCP) return t + words_to_bytes(doff);
    if (proto == PR_UDP) return t + OFF_W'(UDP_HDR);
    return t;
  endfunction
endpackage

// File: rtl/hfx_lane_walk.sv
`timescale 1ns/1ps
// Walks the lanes of one beat in wire order. Each lane sees the header
// state left by the lanes before it, so a dependency inside one beat resolves.
module hfx_lane_walk
  import hfx_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  hdr_t               st_hdr,
  input  logic [OFF_W-1:0]   st_cnt,
  input  logic               st_done,
  input  logic               sop,
  input  logic               eop,
  input  logic [8*BYTES-1:0] data,
  input  logic [BYTES-1:0]   keep,
  output hdr_t               nx_hdr,
  output logic [OFF_W-1:0]   nx_cnt,
  output logic               nx_done,
  output logic               hit,
  output logic [LANE_W-1:0]  hit_lane
);
  always_comb begin : walk
    hdr_t             h;
    logic [OFF_W-1:0] base;
    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] t;
    logic             d;
    logic [7:0]       b;
    h        = sop ? '0 : st_hdr;
    base     = sop ? '0 : st_cnt;
    d        = sop ? 1'b0 : st_done;
    hit      = 1'b0;
    hit_lane = '0;
    off      = '0;
    t        = '0;
    b        = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (!eop || keep[i]) begin
        b   = data[8*i +: 8];
        off = base + OFF_W'(i);
        t   = l4_off(h.ihl);
        if (off == POS_ET_HI)    h.etype[15:8] = b;
        if (off == POS_ET_LO)    h.etype[7:0]  = b;
        if (off == POS_IP_START) begin
          h.ver = b[7:4];
          h.ihl = b[3:0];
        end
        if (off == POS_PROTO)    h.proto = b;
        for (int k = 0; k < 4; k++) begin
          if (off == POS_SIP + OFF_W'(k)) h.sip[31-8*k -: 8] = b;
          if (off == POS_DIP + OFF_W'(k)) h.dip[31-8*k -: 8] = b;
        end
        // transport fields sit after a header of variable length
        if (off == t + L4_SPORT)            h.sport[15:8] = b;
        if (off == t + L4_SPORT + OFF_W'(1)) h.sport[7:0] = b;
        if (off == t + L4_DPORT)            h.dport[15:8] = b;
        if (off == t + L4_DPORT + OFF_W'(1)) h.dport[7:0] = b;
        if (off == t + L4_DOFF)             h.doff        = b[7:4];
        if (off == t + L4_FLAGS)            h.flags       = b;
        if (!d && is_ipv4(h.etype, h.ver) &&
            off == pay_off(h.ihl, h.proto, h.doff)) begin
          hit      = 1'b1;
          hit_lane = LANE_W'(i);
          d        = 1'b1;
        end
      end
    end
    nx_hdr  = h;
    nx_cnt  = base + OFF_W'(BYTES);
    nx_done = d;
  end
endmodule

// File: rtl/hfx_out_reg.sv
`timescale 1ns/1ps
// Single output register stage with valid/ready handshake
module hfx_out_reg #(
  parameter int BYTES  = 4,
  parameter int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [8*BYTES-1:0] in_data,
  input  logic [BYTES-1:0]   in_keep,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic               in_pstart,
  input  logic [LANE_W-1:0]  in_plane,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [8*BYTES-1:0] out_data,
  output logic [BYTES-1:0]   out_keep,
  output logic               out_sop,
  output logic               out_eop,
  output logic               out_pstart,
  output logic [LANE_W-1:0]  out_plane
);
  logic load;
  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_keep   <= '0;
      out_sop    <= 1'b0;
      out_eop    <= 1'b0;
      out_pstart <= 1'b0;
      out_plane  <= '0;
    end else begin
      if (load) begin
        out_valid  <= 1'b1;
        out_data   <= in_data;
        out_keep   <= in_keep;
        out_sop    <= in_sop;
        out_eop    <= in_eop;
        out_pstart <= in_pstart;
        out_plane  <= in_plane;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
      $stable(out_keep) && $stable(out_pstart) && $stable(out_plane) &&
      $stable(out_sop) && $stable(out_eop));

  a_r11_pstart_lane_kept: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_pstart && out_eop |->
      |(out_keep & (BYTES'(1) << out_plane)));
endmodule

// File: rtl/hfx_rec_snap.sv
`timescale 1ns/1ps
// Holds the record registers. A single trigger loads them and pulses the strobe.
module hfx_rec_snap
  import hfx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        trig,
  input  logic        ip,
  input  logic [7:0]  proto,
  input  logic [31:0] sip,
  input  logic [31:0] dip,
  input  logic [15:0] sport,
  input  logic [15:0] dport,
  input  logic [7:0]  flags,
  output logic        rec_valid,
  output logic        rec_not_ipv4,
  output logic [7:0]  rec_proto,
  output logic [31:0] rec_src_ip,
  output logic [31:0] rec_dst_ip,
  output logic [15:0] rec_src_port,
  output logic [15:0] rec_dst_port,
  output logic [7:0]  rec_tcp_flags
);
  logic is_tcp, is_l4;
  assign is_tcp = ip && (proto == PR_TCP);
  assign is_l4  = is_tcp || (ip && (proto == PR_UDP));

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid     <= 1'b0;
      rec_not_ipv4  <= 1'b0;
      rec_proto     <= '0;
      rec_src_ip    <= '0;
      rec_dst_ip    <= '0;
      rec_src_port  <= '0;
      rec_dst_port  <= '0;
      rec_tcp_flags <= '0;
    end else begin
      rec_valid <= trig;
      if (trig) begin
        rec_not_ipv4  <= !ip;
        rec_proto     <= ip ? proto : '0;
        rec_src_ip    <= ip ? sip : '0;
        rec_dst_ip    <= ip ? dip : '0;
        rec_src_port  <= is_l4 ? sport : '0;
        rec_dst_port  <= is_l4 ? dport : '0;
        rec_tcp_flags <= is_tcp ? flags : '0;
      end
    end
  end

  a_r5_ports_zero_other: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_proto != PR_TCP && rec_proto != PR_UDP |->
      rec_src_port == 16'd0 && rec_dst_port == 16'd0 && rec_tcp_flags == 8'd0);
endmodule

// File: rtl/hfx_extract.sv
`timescale 1ns/1ps
module hfx_extract
  import hfx_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [8*BYTES-1:0] in_data,
  input  logic [BYTES-1:0]   in_keep,
  input  logic               in_sop,
  input  logic               in_eop,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [8*BYTES-1:0] out_data,
  output logic [BYTES-1:0]   out_keep,
  output logic               out_sop,
  output logic               out_eop,
  output logic               out_pstart,
  output logic [LANE_W-1:0]  out_plane,
  output logic               rec_valid,
  output logic               rec_not_ipv4,
  output logic [7:0]         rec_proto,
  output logic [31:0]        rec_src_ip,
  output logic [31:0]        rec_dst_ip,
  output logic [15:0]        rec_src_port,
  output logic [15:0]        rec_dst_port,
  output logic [7:0]         rec_tcp_flags
);
  generate
    if (BYTES != 1 && BYTES != 2 && BYTES != 4) begin : g_bad_bytes
      $error("hfx_extract: BYTES must be 1, 2 or 4");
    end
  endgenerate

  hdr_t             hdr_q, hdr_n;
  logic [OFF_W-1:0] cnt_q, cnt_n;
  logic             done_q, done_n;
  logic             hit;
  logic [LANE_W-1:0] hit_lane;
  logic             accept, trig;

  assign accept = in_valid && in_ready;
  // record fires on the payload-start beat, or at frame end if none came
  assign trig   = accept && (hit || (in_eop && !done_n));

  hfx_lane_walk #(.BYTES(BYTES), .LANE_W(LANE_W)) walk_i (
    .st_hdr  (hdr_q),
    .st_cnt  (cnt_q),
    .st_done (done_q),
    .sop     (in_sop),
    .eop     (in_eop),
    .data    (in_data),
    .keep    (in_keep),
    .nx_hdr  (hdr_n),
    .nx_cnt  (cnt_n),
    .nx_done (done_n),
    .hit     (hit),
    .hit_lane(hit_lane)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (accept) begin
      hdr_q  <= hdr_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  hfx_out_reg #(.BYTES(BYTES), .LANE_W(LANE_W)) oreg_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_keep   (in_keep),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_pstart (hit),
    .in_plane  (hit_lane),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_keep  (out_keep),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_pstart(out_pstart),
    .out_plane (out_plane)
  );

  hfx_rec_snap rec_i (
    .clk          (clk),
    .rst          (rst),
    .trig         (trig),
    .ip           (is_ipv4(hdr_n.etype, hdr_n.ver)),
    .proto        (hdr_n.proto),
    .sip          (hdr_n.sip),
    .dip          (hdr_n.dip),
    .sport        (hdr_n.sport),
    .dport        (hdr_n.dport),
    .flags        (hdr_n.flags),
    .rec_valid    (rec_valid),
    .rec_not_ipv4 (rec_not_ipv4),
    .rec_proto    (rec_proto),
    .rec_src_ip   (rec_src_ip),
    .rec_dst_ip   (rec_dst_ip),
    .rec_src_port (rec_src_port),
    .rec_dst_port (rec_dst_port),
    .rec_tcp_flags(rec_tcp_flags)
  );

  a_r7_rec_with_beat: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> out_valid && (out_pstart || out_eop));

  a_r6_notip_no_pstart: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_not_ipv4 |-> !out_pstart);
endmodule

// File: tb/hfx_extract_tb_top.sv
`timescale 1ns/1ps
module hfx_extract_tb_top;
  localparam int BYTES = 4;
  localparam int LW    = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst;
  logic               in_valid, in_ready, in_sop, in_eop;
  logic [8*BYTES-1:0] in_data;
  logic [BYTES-1:0]   in_keep;
  logic               out_valid, out_ready, out_sop, out_eop, out_pstart;
  logic [8*BYTES-1:0] out_data;
  logic [BYTES-1:0]   out_keep;
  logic [LW-1:0]      out_plane;
  logic               rec_valid, rec_not_ipv4;
  logic [7:0]         rec_proto, rec_tcp_flags;
  logic [31:0]        rec_src_ip, rec_dst_ip;
  logic [15:0]        rec_src_port, rec_dst_port;

  hfx_extract #(.BYTES(BYTES)) dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_keep(in_keep), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_keep(out_keep), .out_sop(out_sop), .out_eop(out_eop),
    .out_pstart(out_pstart), .out_plane(out_plane),
    .rec_valid(rec_valid), .rec_not_ipv4(rec_not_ipv4), .rec_proto(rec_proto),
    .rec_src_ip(rec_src_ip), .rec_dst_ip(rec_dst_ip),
    .rec_src_port(rec_src_port), .rec_dst_port(rec_dst_port),
    .rec_tcp_flags(rec_tcp_flags)
  );

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0] fr [0:255];
  int         fr_len;
  logic [7:0] obuf [0:255];
  int         ob, p_cnt, p_off, r_cnt;
  bit         r_on_beat;
  logic       m_notip;
  logic [7:0] m_proto, m_flags;
  logic [31:0] m_sip, m_dip;
  logic [15:0] m_sport, m_dport;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // output monitor, sampled well after the negative edge
  always begin
    @(negedge clk);
    #2;
    if (!rst && out_valid && out_ready) begin
      if (out_sop) ob = 0;
      if (out_pstart) begin
        p_cnt++;
        p_off = ob + int'(out_plane);
      end
      for (int i = 0; i < BYTES; i++)
        if (!out_eop || out_keep[i]) begin
          obuf[ob] = out_data[8*i +: 8];
          ob++;
        end
    end
    if (!rst && rec_valid) begin
      r_cnt++;
      r_on_beat = out_valid && (out_pstart || out_eop);
      m_notip = rec_not_ipv4; m_proto = rec_proto; m_flags = rec_tcp_flags;
      m_sip = rec_src_ip; m_dip = rec_dst_ip;
      m_sport = rec_src_port; m_dport = rec_dst_port;
    end
  end

  function automatic int words(input int w);
    return (w < 5) ? 20 : 4 * w;
  endfunction

  function automatic int exp_pay(input int proto, input int ihl, input int doff);
    int t = 14 + words(ihl);
    if (proto == 6)  return t + words(doff);
    if (proto == 17) return t + 8;
    return t;
  endfunction

  task automatic build(input logic [15:0] et, input logic [3:0] ver, input logic [3:0] ihl,
                       input logic [7:0] proto, input logic [3:0] doff,
                       input logic [7:0] flags, input int len);
    int t = 14 + words(int'(ihl));
    for (int k = 0; k < 256; k++) fr[k] = 8'(k * 7 + 3);
    fr[12] = et[15:8]; fr[13] = et[7:0]; fr[14] = {ver, ihl}; fr[23] = proto;
    fr[26] = 8'hC0; fr[27] = 8'hA8; fr[28] = 8'h01; fr[29] = 8'h0A;
    fr[30] = 8'h0A; fr[31] = 8'h00; fr[32] = 8'h00; fr[33] = 8'h05;
    fr[t] = 8'h1F; fr[t+1] = 8'h90; fr[t+2] = 8'hC3; fr[t+3] = 8'h50;
    fr[t+12] = {doff, 4'h0}; fr[t+13] = flags;
    fr_len = len;
  endtask

  task automatic send(input bit bp);
    int nb   = (fr_len + BYTES - 1) / BYTES;
    int b    = 0;
    int step = 0;
    p_cnt = 0; p_off = -1; r_cnt = 0; ob = 0; r_on_beat = 0;
    while (b < nb) begin
      @(negedge clk);
      out_ready = bp ? (step % 3 != 1) : 1'b1;
      step++;
      in_valid = 1'b1;
      in_sop   = (b == 0);
      in_eop   = (b == nb - 1);
      for (int i = 0; i < BYTES; i++) begin
        in_data[8*i +: 8] = (b*BYTES + i < fr_len) ? fr[b*BYTES + i] : 8'h00;
        in_keep[i]        = (b*BYTES + i < fr_len);
      end
      #1;
      if (in_ready) b++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_ip_rec(input string req, input logic [7:0] proto,
                            input bit ports, input logic [7:0] flags);
    chk(r_cnt == 1, {req, " one record pulse (R7)"}, r_cnt, 1);
    chk(r_on_beat, {req, " record on closing beat (R7)"}, r_on_beat, 1);
    chk(m_notip == 1'b0, {req, " ipv4 seen (R2)"}, m_notip, 0);
    chk(m_proto == proto, {req, " protocol (R2)"}, m_proto, proto);
    chk(m_sip == 32'hC0A8010A, {req, " source address (R2)"}, m_sip, 32'hC0A8010A);
    chk(m_dip == 32'h0A000005, {req, " destination address (R2)"}, m_dip, 32'h0A000005);
    chk(m_sport == (ports ? 16'h1F90 : 16'h0), {req, " source port"}, m_sport,
        ports ? 16'h1F90 : 16'h0);
    chk(m_dport == (ports ? 16'hC350 : 16'h0), {req, " destination port"}, m_dport,
        ports ? 16'hC350 : 16'h0);
    chk(m_flags == flags, {req, " flags"}, m_flags, flags);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(rec_valid == 1'b0, "R1 rec_valid in reset", rec_valid, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(out_valid == 1'b0 && rec_valid == 1'b0, "R1 idle after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_tcp_basic;
    build(16'h0800, 4'd4, 4'd5, 8'd6, 4'd5, 8'h12, 80);
    send(0);
    chk(p_cnt == 1, "R3 tcp one payload flag", p_cnt, 1);
    chk(p_off == exp_pay(6, 5, 5), "R3 tcp payload offset", p_off, exp_pay(6, 5, 5));
    chk_ip_rec("R2 tcp basic R3", 8'd6, 1, 8'h12);
  endtask

  task automatic t_tcp_options;
    build(16'h0800, 4'd4, 4'd6, 8'd6, 4'd8, 8'h18, 100);
    send(0);
    chk(p_off == exp_pay(6, 6, 8), "R3 tcp options skipped", p_off, exp_pay(6, 6, 8));
    chk_ip_rec("R3 tcp options", 8'd6, 1, 8'h18);
  endtask

  task automatic t_udp;
    build(16'h0800, 4'd4, 4'd5, 8'd17, 4'd5, 8'hFF, 70);
    send(0);
    chk(p_off == exp_pay(17, 5, 0), "R4 udp payload offset", p_off, exp_pay(17, 5, 0));
    chk_ip_rec("R4 udp", 8'd17, 1, 8'h00);
  endtask

  task automatic t_other_proto;
    build(16'h0800, 4'd4, 4'd5, 8'd1, 4'd5, 8'hFF, 60);
    send(0);
    chk(p_off == exp_pay(1, 5, 0), "R5 other payload offset", p_off, exp_pay(1, 5, 0));
    chk_ip_rec("R5 other proto", 8'd1, 0, 8'h00);
  endtask

  task automatic t_not_ip;
    build(16'h86DD, 4'd6, 4'd0, 8'd6, 4'd5, 8'h12, 80);
    send(0);
    chk(p_cnt == 0, "R6 no payload flag non-ipv4", p_cnt, 0);
    chk(r_cnt == 1 && r_on_beat, "R6 record with end beat", r_cnt, 1);
    chk(m_notip == 1'b1, "R6 not-ipv4 indication", m_notip, 1);
    chk(m_sip == 0 && m_sport == 0 && m_proto == 0 && m_flags == 0,
        "R6 fields zeroed", m_sip, 0);
    build(16'h0800, 4'd6, 4'd5, 8'd6, 4'd5, 8'h12, 80);
    send(0);
    chk(m_notip == 1'b1 && p_cnt == 0, "R6 wrong version rejected", m_notip, 1);
  endtask

  task automatic t_short_len;
    build(16'h0800, 4'd4, 4'd2, 8'd6, 4'd1, 8'h02, 80);
    send(0);
    chk(p_off == 54, "R8 short length fields clamped", p_off, 54);
    chk_ip_rec("R8 clamped", 8'd6, 1, 8'h02);
  endtask

  task automatic t_truncated;
    build(16'h0800, 4'd4, 4'd5, 8'd6, 4'd5, 8'h12, 40);
    send(0);
    chk(p_cnt == 0, "R10 no payload flag when truncated", p_cnt, 0);
    chk(r_cnt == 1 && r_on_beat, "R10 record with end beat", r_cnt, 1);
    chk(m_sport == 16'h1F90 && m_dport == 16'hC350, "R10 ports captured", m_sport, 16'h1F90);
    chk(m_flags == 8'h00, "R10 missing flags read zero", m_flags, 0);
    build(16'h0800, 4'd4, 4'd5, 8'd6, 4'd5, 8'h12, 54);
    send(0);
    chk(p_cnt == 0, "R10 frame ends at payload offset", p_cnt, 0);
    chk(m_flags == 8'h12 && r_cnt == 1, "R10 full header record", m_flags, 8'h12);
  endtask

  task automatic t_backpressure;
    int bad = 0;
    build(16'h0800, 4'd4, 4'd5, 8'd6, 4'd5, 8'h11, 97);
    send(1);
    for (int k = 0; k < 97; k++) if (obuf[k] !== fr[k]) bad++;
    chk(bad == 0, "R9 bytes forwarded unchanged under stall", bad, 0);
    chk(ob == 97, "R11 partial last beat byte count", ob, 97);
    chk(p_off == 54 && p_cnt == 1, "R9 payload flag under stall", p_off, 54);
    chk(r_cnt == 1 && r_on_beat, "R7 record under stall", r_cnt, 1);
  endtask

  task automatic t_tail_lane;
    build(16'h0800, 4'd4, 4'd5, 8'd6, 4'd5, 8'h10, 55);
    send(0);
    chk(p_cnt == 1 && p_off == 54, "R11 payload on last valid lane", p_off, 54);
    chk(r_cnt == 1 && r_on_beat, "R11 record on partial beat", r_cnt, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    in_data = '0; in_keep = '0; out_ready = 1'b1;
    t_reset();
    t_tcp_basic();
    t_tcp_options();
    t_udp();
    t_other_proto();
    t_not_ip();
    t_short_len();
    t_truncated();
    t_backpressure();
    t_tail_lane();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule